// File: doc/BRIEF.md
# Chain Conversion Readback Sequencer

This block runs one full measurement pass over a daisy chain of battery-monitor devices. It talks to the chain through a 32-bit frame port. A separate frame codec and serial shifter sit behind that port. The port offers a frame with a request, and a one-cycle acknowledge returns the frame that came back in the same transfer. On a start pulse the sequencer first broadcasts a write that points every device's read pointer at its first cell result. It then broadcasts a control write that launches a conversion started by chip-select.

After that it waits for a delay computed from the chain length, the acquisition-time code and the averaging code. It then reads one frame per channel for every device, twelve per device. Each returned frame is CRC-checked and split into device, channel and data fields. The data is compared against a pair of cell thresholds or a pair of auxiliary thresholds, which raises a rising or falling alert. Cell results (channel codes 0 to 5) are added to a running sum. The first frame with a bad CRC stops the pass with an error.

Top module: `rdb_chain_sequencer`

## Requirements
- R1: After reset, busy, done, err, res_valid and fr_req are 0 and cell_sum is 0.
- R2: The first frame of a pass is a broadcast write of the read-pointer register. Its fields are: device address 0 in bits [31:27], register 0x1C in bits [26:21], data 0x00 in bits [20:13], and broadcast flag 1 in bit 12. Bits [10:3] hold the CRC, bit 1 is 1, and all other bits are 0. The CRC is computed over bits [31:11] as a 24-bit value v: c = T(T(v[23:16]) ^ v[15:8]) ^ v[7:0]. T is eight MSB-first shifts with polynomial 0x2F.
- R3: The second frame is a broadcast write of the control-high register 0x0D, in the same layout as R2. Its data byte has bit 3 set (start by chip-select), the averaging code in bits [2:1], and every other bit 0.
- R4: The first read request appears exactly C cycles after the edge that accepts the control write. C = CLK_PER_US × (ceil(ns/1000) + 5), where ns = (tA + 695)·12·avg − tA + (devices − 1)·250. tA is 465, 1010, 1460 or 1890 for acq_sel 0 to 3, and avg is 2^avg_sel.
- R5: A pass issues exactly devices × 12 read frames, each carrying 0xF800030A. A num_dev of 0 counts as 1 device, and values above MAX_DEV count as MAX_DEV.
- R6: A returned frame passes when its bits [9:2] equal the R2 CRC of bits [31:10]. The first failing frame ends the pass: done and err rise in the next cycle, no result is issued for that frame, and no further frame is requested.
- R7: For each passing read frame, res_valid pulses in the cycle after the acknowledge. It carries bits [31:27] as res_dev, bits [26:23] as res_chan and bits [22:11] as res_data.
- R8: cell_sum, valid while done is high, is the sum of res_data over results with res_chan ≤ 5.
- R9: A result with res_chan ≤ 5 is compared against the cell thresholds, and any other result against the auxiliary thresholds. res_rise is set when data ≥ high. Otherwise res_fall is set when data ≤ low.
- R10: The thresholds are written by thr_wr with thr_sel 0 = cell high, 1 = cell low, 2 = aux high, 3 = aux low. Both high thresholds reset to 0xFF and both low thresholds reset to 0x00.
- R11: start is accepted only while idle. busy is high from the cycle after start until the cycle done is high. done is a single-cycle pulse, and a start during a pass has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass (idle only) |
| num_dev | input | NDEV_W | Devices in the chain |
| acq_sel | input | 2 | Acquisition-time code |
| avg_sel | input | 2 | Averaging code |
| thr_wr | input | 1 | Threshold write strobe |
| thr_sel | input | 2 | Threshold selector |
| thr_val | input | 8 | Threshold value |
| fr_req | output | 1 | Frame transfer request |
| fr_tx | output | 32 | Frame to send |
| fr_ack | input | 1 | Transfer complete |
| fr_rx | input | 32 | Frame received |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Pass finished (pulse) |
| err | output | 1 | Pass ended on CRC failure |
| res_valid | output | 1 | Per-frame result valid |
| res_dev | output | 5 | Device field of result |
| res_chan | output | 4 | Channel code of result |
| res_data | output | 12 | Conversion data |
| res_rise | output | 1 | At or above high threshold |
| res_fall | output | 1 | At or below low threshold |
| cell_sum | output | SUM_W | Sum of cell results |

## Verification
The hardest condition to reach is a CRC failure in the middle of a chain. It has to land on a chosen read, and the check is that no result for it and no later request follow. The bench's frame responder builds every return frame with a correct CRC and flips one CRC bit on a chosen index, including index 0. A second hard spot is the exact wait length for the extreme codes. The bench therefore counts idle cycles between the control-write acknowledge and the first read request, running a clamped over-size chain with the longest acquisition time and the most averaging.

// File: rtl/rdb_pkg.sv
package rdb_pkg;

    localparam int FRAME_W       = 32;
    localparam int DATA_W        = 12;
    localparam int CELLS_PER_DEV = 6;
    localparam int CH_PER_DEV    = 12;
    localparam int MAX_WAIT_US   = 260;

    localparam logic [5:0]  REG_CTRL_HI  = 6'h0D;
    localparam logic [5:0]  REG_READ_PTR = 6'h1C;
    localparam logic [31:0] READ_FILL    = 32'hF800_030A;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PTR, ST_CTL, ST_WAIT, ST_READ, ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic [7:0] cell_hi;
        logic [7:0] cell_lo;
        logic [7:0] aux_hi;
        logic [7:0] aux_lo;
    } thresholds_t;

    typedef struct packed {
        logic [4:0]        dev;
        logic [3:0]        chan;
        logic [DATA_W-1:0] data;
        logic              crc_ok;
        logic              is_cell;
        logic              rise;
        logic              fall;
    } frame_result_t;

    // eight MSB-first shifts through polynomial 0x2F
    function automatic logic [7:0] crc_step(input logic [7:0] b);
        logic [7:0] c;
        c = b;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ 8'h2F) : (c << 1);
        end
        return c;
    endfunction

    function automatic logic [7:0] crc_word(input logic [23:0] v);
        return crc_step(crc_step(v[23:16]) ^ v[15:8]) ^ v[7:0];
    endfunction

    function automatic logic [31:0] build_write(input logic [4:0] dev,
                                                input logic [5:0] regsel,
                                                input logic [7:0] data,
                                                input logic       bcast);
        logic [31:0] f;
        f       = {dev, regsel, data, bcast, 12'h000};
        f[10:3] = crc_word({3'b000, f[31:11]});
        f[1]    = 1'b1;
        return f;
    endfunction

    // settle time in whole microseconds, margin included
    function automatic logic [8:0] wait_us(input logic [7:0] ndev,
                                           input logic [1:0] acq,
                                           input logic [1:0] avg);
        logic [19:0] tacq;
        logic [19:0] ns;
        case (acq)
            2'd0:    tacq = 20'd465;
            2'd1:    tacq = 20'd1010;
            2'd2:    tacq = 20'd1460;
            default: tacq = 20'd1890;
        endcase
        ns = (((tacq + 20'd695) * 20'd12) << avg) - tacq
             + ({12'h000, ndev} - 20'd1) * 20'd250;
        return 9'((ns + 20'd999) / 20'd1000 + 20'd5);
    endfunction

endpackage

// File: rtl/rdb_thresh_regs.sv
module rdb_thresh_regs
    import rdb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [1:0]  sel,
    input  logic [7:0]  val,
    output thresholds_t thr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr.cell_hi <= 8'hFF;
            thr.cell_lo <= 8'h00;
            thr.aux_hi  <= 8'hFF;
            thr.aux_lo  <= 8'h00;
        end else if (wr) begin
            case (sel)
                2'd0:    thr.cell_hi <= val;
                2'd1:    thr.cell_lo <= val;
                2'd2:    thr.aux_hi  <= val;
                default: thr.aux_lo  <= val;
            endcase
        end
    end

    // R10: reset values of the threshold pairs
    a_r10_reset_values: assert property (@(posedge clk)
        $past(rst) |-> (thr.cell_hi == 8'hFF && thr.aux_hi == 8'hFF &&
                        thr.cell_lo == 8'h00 && thr.aux_lo == 8'h00));

endmodule

// File: rtl/rdb_wait_timer.sv
module rdb_wait_timer
    import rdb_pkg::*;
#(
    parameter int CLK_PER_US = 10,
    parameter int NDEV_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [NDEV_W-1:0] ndev,
    input  logic [1:0]        acq,
    input  logic [1:0]        avg,
    output logic              zero
);

    localparam int CNT_W = $clog2(MAX_WAIT_US * CLK_PER_US + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] span;

    always_comb begin
        span = CNT_W'(wait_us(8'(ndev), acq, avg)) * CNT_W'(CLK_PER_US);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= span - CNT_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign zero = (cnt == '0);

    // R4: a freshly loaded wait never finishes in the next cycle
    a_r4_load_not_expired: assert property (@(posedge clk) disable iff (rst)
        load |=> !zero);

endmodule

// File: rtl/rdb_frame_eval.sv
module rdb_frame_eval
    import rdb_pkg::*;
(
    input  logic [FRAME_W-1:0] rx,
    input  thresholds_t        thr,
    output frame_result_t      res
);

    logic [7:0]        hi_sel;
    logic [7:0]        lo_sel;
    logic [DATA_W-1:0] data;
    logic              unused_tail;

    assign unused_tail = ^rx[1:0];
    assign data        = rx[22:11];

    always_comb begin
        res.dev     = rx[31:27];
        res.chan    = rx[26:23];
        res.data    = data;
        res.crc_ok  = (crc_word({2'b00, rx[31:10]}) == rx[9:2]);
        res.is_cell = (rx[26:23] < 4'(CELLS_PER_DEV));
        hi_sel      = res.is_cell ? thr.cell_hi : thr.aux_hi;
        lo_sel      = res.is_cell ? thr.cell_lo : thr.aux_lo;
        res.rise    = (data >= {4'h0, hi_sel});
        res.fall    = !res.rise && (data <= {4'h0, lo_sel});
    end

endmodule

// File: rtl/rdb_chain_sequencer.sv
module rdb_chain_sequencer
    import rdb_pkg::*;
#(
    parameter int MAX_DEV    = 8,
    parameter int CLK_PER_US = 10,
    localparam int NDEV_W    = $clog2(MAX_DEV + 1),
    localparam int SUM_W     = $clog2(MAX_DEV * CELLS_PER_DEV * ((1 << DATA_W) - 1) + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [NDEV_W-1:0]  num_dev,
    input  logic [1:0]         acq_sel,
    input  logic [1:0]         avg_sel,
    input  logic               thr_wr,
    input  logic [1:0]         thr_sel,
    input  logic [7:0]         thr_val,
    output logic               fr_req,
    output logic [31:0]        fr_tx,
    input  logic               fr_ack,
    input  logic [31:0]        fr_rx,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               res_valid,
    output logic [4:0]         res_dev,
    output logic [3:0]         res_chan,
    output logic [11:0]        res_data,
    output logic               res_rise,
    output logic               res_fall,
    output logic [SUM_W-1:0]   cell_sum
);

    localparam int RD_MAX = MAX_DEV * CH_PER_DEV;
    localparam int RD_W   = $clog2(RD_MAX + 1);

    seq_state_t        state;
    logic [NDEV_W-1:0] ndev_q;
    logic [1:0]        acq_q;
    logic [1:0]        avg_q;
    logic [NDEV_W-1:0] ndev_clamped;
    logic [RD_W-1:0]   rd_cnt;
    logic [RD_W-1:0]   rd_total;
    logic              wait_zero;
    logic              wait_load;
    thresholds_t       thr;
    frame_result_t     ev;

    rdb_thresh_regs u_thr (
        .clk (clk),
        .rst (rst),
        .wr  (thr_wr),
        .sel (thr_sel),
        .val (thr_val),
        .thr (thr)
    );

    assign wait_load = (state == ST_CTL) && fr_ack;

    rdb_wait_timer #(
        .CLK_PER_US (CLK_PER_US),
        .NDEV_W     (NDEV_W)
    ) u_wait (
        .clk  (clk),
        .rst  (rst),
        .load (wait_load),
        .ndev (ndev_q),
        .acq  (acq_q),
        .avg  (avg_q),
        .zero (wait_zero)
    );

    rdb_frame_eval u_eval (
        .rx  (fr_rx),
        .thr (thr),
        .res (ev)
    );

    always_comb begin
        if (num_dev == '0) begin
            ndev_clamped = NDEV_W'(1);
        end else if (num_dev > NDEV_W'(MAX_DEV)) begin
            ndev_clamped = NDEV_W'(MAX_DEV);
        end else begin
            ndev_clamped = num_dev;
        end
    end

    assign rd_total = RD_W'(ndev_q) * RD_W'(CH_PER_DEV);

    always_comb begin
        case (state)
            ST_PTR:  fr_tx = build_write(5'd0, REG_READ_PTR, 8'h00, 1'b1);
            ST_CTL:  fr_tx = build_write(5'd0, REG_CTRL_HI,
                                         {4'b0000, 1'b1, avg_q, 1'b0}, 1'b1);
            ST_READ: fr_tx = READ_FILL;
            default: fr_tx = '0;
        endcase
    end

    assign fr_req = (state == ST_PTR) || (state == ST_CTL) || (state == ST_READ);
    assign busy   = (state != ST_IDLE);
    assign done   = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ndev_q    <= NDEV_W'(1);
            acq_q     <= '0;
            avg_q     <= '0;
            rd_cnt    <= '0;
            err       <= 1'b0;
            cell_sum  <= '0;
            res_valid <= 1'b0;
            res_dev   <= '0;
            res_chan  <= '0;
            res_data  <= '0;
            res_rise  <= 1'b0;
            res_fall  <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        ndev_q   <= ndev_clamped;
                        acq_q    <= acq_sel;
                        avg_q    <= avg_sel;
                        rd_cnt   <= '0;
                        err      <= 1'b0;
                        cell_sum <= '0;
                        state    <= ST_PTR;
                    end
                end
                ST_PTR: begin
                    if (fr_ack) state <= ST_CTL;
                end
                ST_CTL: begin
                    if (fr_ack) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (wait_zero) state <= ST_READ;
                end
                ST_READ: begin
                    if (fr_ack) begin
                        if (!ev.crc_ok) begin
                            err   <= 1'b1;
                            state <= ST_DONE;
                        end else begin
                            res_valid <= 1'b1;
                            res_dev   <= ev.dev;
                            res_chan  <= ev.chan;
                            res_data  <= ev.data;
                            res_rise  <= ev.rise;
                            res_fall  <= ev.fall;
                            if (ev.is_cell) begin
                                cell_sum <= cell_sum + SUM_W'(ev.data);
                            end
                            rd_cnt <= rd_cnt + RD_W'(1);
                            if (rd_cnt == rd_total - RD_W'(1)) begin
                                state <= ST_DONE;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: a pass only begins from a start request
    a_r11_start_begins: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R8: auxiliary results leave the sum unchanged
    a_r8_aux_not_summed: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_chan > 4'd5) |-> $stable(cell_sum));

    // R9: the two alerts never coincide
    a_r9_alert_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(res_rise && res_fall));

    // R6: an error is only raised as the pass ends
    a_r6_err_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);

    // R2: a pending frame holds its content until accepted
    a_r2_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (fr_req && !fr_ack) |=> (fr_req && $stable(fr_tx)));

endmodule

// File: tb/test_rdb_chain_sequencer.sv
module test_rdb_chain_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  num_dev = 4'd1;
    logic [1:0]  acq_sel = 2'd0;
    logic [1:0]  avg_sel = 2'd0;
    logic        thr_wr = 1'b0;
    logic [1:0]  thr_sel = 2'd0;
    logic [7:0]  thr_val = 8'h00;
    logic        fr_req;
    logic [31:0] fr_tx;
    logic        fr_ack = 1'b0;
    logic [31:0] fr_rx = 32'h0;
    logic        busy, done, err, res_valid, res_rise, res_fall;
    logic [4:0]  res_dev;
    logic [3:0]  res_chan;
    logic [11:0] res_data;
    logic [17:0] cell_sum;

    int checks = 0;
    int fails  = 0;
    logic [7:0] t_chi = 8'hFF, t_clo = 8'h00, t_ahi = 8'hFF, t_alo = 8'h00;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rdb_chain_sequencer #(.MAX_DEV(8), .CLK_PER_US(CPU)) i_rdb_chain_sequencer (
        .clk(clk), .rst(rst), .start(start), .num_dev(num_dev),
        .acq_sel(acq_sel), .avg_sel(avg_sel), .thr_wr(thr_wr),
        .thr_sel(thr_sel), .thr_val(thr_val), .fr_req(fr_req),
        .fr_tx(fr_tx), .fr_ack(fr_ack), .fr_rx(fr_rx), .busy(busy),
        .done(done), .err(err), .res_valid(res_valid), .res_dev(res_dev),
        .res_chan(res_chan), .res_data(res_data), .res_rise(res_rise),
        .res_fall(res_fall), .cell_sum(cell_sum)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] tb_crc(input logic [23:0] v);
        logic [7:0] c;
        c = v[23:16];
        for (int k = 0; k < 16; k++) begin
            if (k == 8) c = c ^ v[15:8];
            c = c[7] ? ((c << 1) ^ 8'h2F) : (c << 1);
        end
        return c ^ v[7:0];
    endfunction

    function automatic logic [31:0] tb_write(input logic [5:0] rg, input logic [7:0] d);
        logic [31:0] f;
        f = {5'd0, rg, d, 1'b1, 12'h000};
        f[10:3] = tb_crc({3'b000, f[31:11]});
        f[1] = 1'b1;
        return f;
    endfunction

    function automatic int tb_wait_cycles(input int nd, input int a, input int v);
        int ta, ns;
        ta = (a == 0) ? 465 : (a == 1) ? 1010 : (a == 2) ? 1460 : 1890;
        ns = (ta + 695) * 12 * (1 << v) - ta + (nd - 1) * 250;
        return ((ns + 999) / 1000 + 5) * CPU;
    endfunction

    function automatic logic [11:0] tb_data(input int r);
        case (r % 12)
            0: return {4'h0, t_chi};
            1: return {4'h0, t_clo};
            6: return {4'h0, t_ahi};
            7: return {4'h0, t_alo};
            default: return 12'((r * 53 + 17) % 400);
        endcase
    endfunction

    task automatic set_thr(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        thr_wr = 1'b1; thr_sel = s; thr_val = v;
        @(negedge clk);
        thr_wr = 1'b0;
    endtask

    task automatic run_seq(input int nd_in, input int a, input int v,
                           input int bad, input bit extra_start);
        int nd, total, cyc, negc, frame, n0, last_r, nres, guard;
        bit fin, poked;
        logic [17:0] esum;
        logic [11:0] d;
        logic [7:0] hi, lo;
        bit erise, efall;
        nd = (nd_in == 0) ? 1 : (nd_in > 8 ? 8 : nd_in);
        total = nd * 12;
        cyc = tb_wait_cycles(nd, a, v);
        negc = 0; frame = 0; n0 = 0; last_r = -1; nres = 0; guard = 0;
        fin = 0; poked = 0; esum = '0;
        @(negedge clk);
        num_dev = 4'(nd_in); acq_sel = 2'(a); avg_sel = 2'(v); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R11", "busy after start", 32'(busy), 1);
        while (!fin && guard < 20000) begin
            if (frame > 0 || negc > 0) @(negedge clk);
            negc++; guard++;
            start = 1'b0;
            if (res_valid) begin
                nres++;
                d = tb_data(last_r);
                check(res_dev == 5'(last_r / 12), "R7", "res_dev", 32'(res_dev), 32'(last_r / 12));
                check(res_chan == 4'(last_r % 12), "R7", "res_chan", 32'(res_chan), 32'(last_r % 12));
                check(res_data == d, "R7", "res_data", 32'(res_data), 32'(d));
                hi = (last_r % 12 < 6) ? t_chi : t_ahi;
                lo = (last_r % 12 < 6) ? t_clo : t_alo;
                erise = (d >= {4'h0, hi});
                efall = !erise && (d <= {4'h0, lo});
                check(res_rise == erise, "R9", "res_rise", 32'(res_rise), 32'(erise));
                check(res_fall == efall, "R9", "res_fall", 32'(res_fall), 32'(efall));
                if (last_r % 12 < 6) esum = esum + 18'(d);
            end
            if (done) begin
                fin = 1;
                check(err == (bad >= 0), "R6", "err at done", 32'(err), 32'(bad >= 0));
                check(cell_sum == esum, "R8", "cell_sum", 32'(cell_sum), 32'(esum));
                check(frame == ((bad >= 0) ? bad + 3 : total + 2), "R5", "frame count",
                      32'(frame), 32'((bad >= 0) ? bad + 3 : total + 2));
                check(nres == ((bad >= 0) ? bad : total), "R6", "result count",
                      32'(nres), 32'((bad >= 0) ? bad : total));
            end
            if (fr_ack) begin
                fr_ack = 1'b0;
            end else if (fr_req && !fin) begin
                if (frame == 0) begin
                    check(fr_tx == tb_write(6'h1C, 8'h00), "R2", "pointer write",
                          fr_tx, tb_write(6'h1C, 8'h00));
                end else if (frame == 1) begin
                    check(fr_tx == tb_write(6'h0D, {4'b0000, 1'b1, 2'(v), 1'b0}), "R3",
                          "control write", fr_tx, tb_write(6'h0D, {4'b0000, 1'b1, 2'(v), 1'b0}));
                    n0 = negc;
                end else begin
                    if (frame == 2)
                        check(negc - n0 == cyc + 1, "R4", "wait cycles",
                              32'(negc - n0 - 1), 32'(cyc));
                    check(fr_tx == 32'hF800_030A, "R5", "read filler", fr_tx, 32'hF800_030A);
                    last_r = frame - 2;
                    fr_rx = {5'(last_r / 12), 4'(last_r % 12), tb_data(last_r), 11'h000};
                    fr_rx[9:2] = tb_crc({2'b00, fr_rx[31:10]});
                    if (last_r == bad) fr_rx[9:2] = fr_rx[9:2] ^ 8'h01;
                end
                frame++;
                fr_ack = 1'b1;
            end else if (extra_start && frame == 2 && !poked) begin
                start = 1'b1;
                poked = 1;
            end
        end
        if (!fin) check(0, "R11", "pass never finished", 0, 1);
        fr_ack = 1'b0;
        start = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R11", "idle after done",
              {30'h0, busy, done}, 0);
        check(fr_req == 1'b0, "R6", "no request after end", 32'(fr_req), 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !err && !res_valid && !fr_req, "R1", "control outputs",
              {27'h0, busy, done, err, res_valid, fr_req}, 0);
        check(cell_sum == '0, "R1", "cell_sum", 32'(cell_sum), 0);
    endtask

    task automatic t_single_dev;      // default thresholds exercise R10 reset values
        run_seq(1, 0, 0, -1, 0);
    endtask

    task automatic t_thresholds;      // R10 writes, R9 both sides of both pairs
        set_thr(2'd0, 8'h90); t_chi = 8'h90;
        set_thr(2'd1, 8'h30); t_clo = 8'h30;
        set_thr(2'd2, 8'hA0); t_ahi = 8'hA0;
        set_thr(2'd3, 8'h50); t_alo = 8'h50;
        run_seq(2, 1, 1, -1, 0);
    endtask

    task automatic t_crc_abort;
        run_seq(3, 2, 2, 17, 0);
        run_seq(1, 0, 1, 0, 0);
    endtask

    task automatic t_start_during_busy;
        run_seq(2, 0, 1, -1, 1);
    endtask

    task automatic t_chain_clamps;
        run_seq(9, 3, 3, -1, 0);
        run_seq(0, 1, 0, -1, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_single_dev();
        t_thresholds();
        t_crc_abort();
        t_start_during_busy();
        t_chain_clamps();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule